// File: doc/BRIEF.md
# Codec Link Reset Controller

This block drives the pins that a host uses to hold a serial audio codec in reset and to quiet the outbound link. It takes a resume-domain reset, two hardware reset events (a power-up event and a hard-reset request), a sleep-state code and register writes. From these it produces the active-low codec reset, the gated serial data out and frame sync pins, and an enable for the pull-downs on the inbound bit clock and data pins. In normal running it passes data out and sync straight from the link engine.

The codec reset is sticky. Hardware only ever asserts it. Software releases it by writing 1 to the go bit. Any hardware reset event, or entry into a deep sleep state, clears the go bit and drops the reset. While the system stays in deep sleep, a software write cannot release it. Release always goes through a one-cycle arming step in which data out and sync are held low, so a codec never sees them at an undefined level when it leaves reset.

Two state machines do the work. The codec-reset machine has the states HELD (reset low, go bit 0), SUSP (deep sleep, reset low, writes ignored), ARM (go bit 1, reset still low, link forced low) and LIVE (reset high). Its transitions are:
- any state to SUSP on deep sleep;
- any state outside deep sleep to HELD on a hardware event;
- HELD to ARM on a go write;
- SUSP to HELD on leaving deep sleep;
- ARM to LIVE on the next cycle without a clear write;
- ARM or LIVE to HELD on a clear write.

The platform-reset machine has the states HOLD, which counts PLAT_HOLD cycles with the link forced low, and RUN. It moves from HOLD to RUN when the count completes. It returns to HOLD on reset, on a hardware event, or while in deep sleep.

Top module: `codec_link_rstctl`

## Requirements
- R1: While `rst_n` is low and right after it rises, `codec_rst_n`, `link_sdo`, `link_sync`, `pd_en` and `rd_data` are all 0.
- R2: A write to `CTRL_ADDR` with bit 0 (go) set, with no hardware event and `sleep_state` below 3, makes `rd_data[0]` read 1 after the next rising edge. `codec_rst_n` rises one edge later. In the cycle between the two edges, `link_sdo` and `link_sync` are 0.
- R3: A write to `CTRL_ADDR` with bit 0 clear drops `codec_rst_n` and `rd_data[0]` to 0 after the next edge. This holds from both ARM and LIVE.
- R4: A one-cycle pulse on `pwrup_evt` or `hardrst_evt` leaves `codec_rst_n`, `rd_data[0]`, `rd_data[1]` and `pd_en` at 0 after that edge. They remain 0 until software writes them again.
- R5: With `sleep_state` at 3 or above (3 = S3, 4 = S4, 5 = S5; 6 and 7 are treated alike), `codec_rst_n` and `rd_data[0]` are 0 after the next edge. Go writes have no effect while in that state. After a return to S0, both stay 0 until software sets go.
- R6: After `rst_n` rises, and after the last edge at which a hardware event or deep sleep was present, `link_sdo` and `link_sync` stay 0 for PLAT_HOLD edges (default 4). From then on they follow `eng_sdo` and `eng_sync`.
- R7: When `sleep_state` is not 0 (1 = S1; code 2 is treated like S1), `link_sdo` and `link_sync` are 0. At code 0 with the platform running and no arming, they equal the engine inputs. S1 has no effect on `codec_rst_n`.
- R8: Bit 1 of a write to `CTRL_ADDR` (link shut-off) reads back on `rd_data[1]`, and `pd_en` equals it, from the next edge.
- R9: When a hardware event and a go write fall in the same cycle, the event wins: go reads 0 and `codec_rst_n` stays 0.
- R10: Writes to any address other than `CTRL_ADDR` (default 6) change neither `rd_data` nor `codec_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Resume-domain reset, asynchronous, active low |
| pwrup_evt | input | 1 | One-cycle pulse: mechanical power-up event |
| hardrst_evt | input | 1 | One-cycle pulse: hard-reset request |
| sleep_state | input | 3 | Sleep code: 0 S0, 1 S1, 3 S3, 4 S4, 5 S5 |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register write address |
| wr_data | input | DW (8) | Write data; bit 0 go, bit 1 shut-off |
| rd_data | output | DW (8) | Current control bits: bit 0 go, bit 1 shut-off |
| eng_sdo | input | 1 | Serial data out from the link engine |
| eng_sync | input | 1 | Frame sync from the link engine |
| codec_rst_n | output | 1 | Codec reset, active low |
| link_sdo | output | 1 | Gated serial data out pin |
| link_sync | output | 1 | Gated frame sync pin |
| pd_en | output | 1 | Pull-down enable for bit clock and data-in pins |

## Verification
The gating of the link outputs is swept over every engine input pair under each shallow sleep code. This separates the running case, where the pins follow the engine, from the S1-like codes, where they are forced low. Each deep code from 3 to 7 is entered in turn, and a go write is attempted during it. This shows the codec reset staying low and sticky across the return. Each hardware event is applied alone and then together with a go write, so that a design which lets the write win, or fails to clear the shut-off bit, shows up. A quick go-then-clear pair checks that reset is never released once arming is cancelled.

// File: rtl/clrc_pkg.sv
package clrc_pkg;

    typedef enum logic [1:0] {
        CR_HELD,
        CR_SUSP,
        CR_ARM,
        CR_LIVE
    } cold_st_e;

    typedef enum logic {
        PR_HOLD,
        PR_RUN
    } plat_st_e;

    // Codes at or above 3 are the deep sleep states.
    function automatic logic is_deep(input logic [2:0] code);
        return code >= 3'd3;
    endfunction

    // Any non-zero code quiets the outbound link.
    function automatic logic is_low_power(input logic [2:0] code);
        return code != 3'd0;
    endfunction

endpackage

// File: rtl/clrc_plat_fsm.sv
module clrc_plat_fsm
    import clrc_pkg::*;
#(
    parameter int PLAT_HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic in_hold
);
    localparam int CW = $clog2(PLAT_HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(PLAT_HOLD - 1);

    plat_st_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PR_HOLD;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (restart) begin
            st_d  = PR_HOLD;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                PR_HOLD: begin
                    if (cnt_q == LAST) begin
                        st_d  = PR_RUN;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PR_RUN: st_d = PR_RUN;
            endcase
        end
    end

    always_comb begin
        in_hold = (st_q == PR_HOLD);
    end

    AST_HOLD_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> in_hold);  // R6
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);  // R6

endmodule

// File: rtl/clrc_cold_fsm.sv
module clrc_cold_fsm
    import clrc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_evt,
    input  logic deep,
    input  logic set_req,
    input  logic clr_req,
    output logic go_bit,
    output logic rst_out_n,
    output logic arming
);
    cold_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CR_HELD;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (deep) begin
            st_d = CR_SUSP;
        end else if (hw_evt) begin
            st_d = CR_HELD;
        end else begin
            unique case (st_q)
                CR_HELD: if (set_req) st_d = CR_ARM;
                CR_SUSP: st_d = CR_HELD;
                CR_ARM:  st_d = clr_req ? CR_HELD : CR_LIVE;
                CR_LIVE: if (clr_req) st_d = CR_HELD;
            endcase
        end
    end

    always_comb begin
        go_bit    = 1'b0;
        rst_out_n = 1'b0;
        arming    = 1'b0;
        unique case (st_q)
            CR_HELD: ;
            CR_SUSP: ;
            CR_ARM: begin
                go_bit = 1'b1;
                arming = 1'b1;
            end
            CR_LIVE: begin
                go_bit    = 1'b1;
                rst_out_n = 1'b1;
            end
        endcase
    end

    AST_EVENT_DROPS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        hw_evt |=> !rst_out_n);  // R4
    AST_DEEP_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        deep |=> (!rst_out_n && !go_bit));  // R5
    AST_EVENT_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_evt && set_req) |=> !go_bit);  // R9
    AST_GO_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go_bit) |-> $past(set_req));  // R2

endmodule

// File: rtl/clrc_cfg_reg.sv
module clrc_cfg_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_evt,
    input  logic wr_hit,
    input  logic wr_off,
    output logic off_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      off_q <= 1'b0;
        else if (hw_evt) off_q <= 1'b0;
        else if (wr_hit) off_q <= wr_off;
    end

    AST_OFF_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !hw_evt) |=> (off_q == $past(wr_off)));  // R8
    AST_OFF_CLEARED_BY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        hw_evt |=> !off_q);  // R4

endmodule

// File: rtl/codec_link_rstctl.sv
module codec_link_rstctl
    import clrc_pkg::*;
#(
    parameter int             AW        = 4,
    parameter int             DW        = 8,
    parameter logic [AW-1:0]  CTRL_ADDR = 4'h6,
    parameter int             GO_BIT    = 0,
    parameter int             OFF_BIT   = 1,
    parameter int             PLAT_HOLD = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwrup_evt,
    input  logic          hardrst_evt,
    input  logic [2:0]    sleep_state,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          eng_sdo,
    input  logic          eng_sync,
    output logic          codec_rst_n,
    output logic          link_sdo,
    output logic          link_sync,
    output logic          pd_en
);
    logic hw_evt, deep, low_pwr, wr_hit, set_req, clr_req;
    logic go_bit, arming, in_hold, off_q, force_low;
    logic unused_wr_bits;

    assign hw_evt   = pwrup_evt | hardrst_evt;
    assign deep     = is_deep(sleep_state);
    assign low_pwr  = is_low_power(sleep_state);
    assign wr_hit   = wr_valid && (wr_addr == CTRL_ADDR);
    assign set_req  = wr_hit &&  wr_data[GO_BIT];
    assign clr_req  = wr_hit && !wr_data[GO_BIT];
    assign unused_wr_bits = ^wr_data;

    clrc_cold_fsm u_cold (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_evt    (hw_evt),
        .deep      (deep),
        .set_req   (set_req),
        .clr_req   (clr_req),
        .go_bit    (go_bit),
        .rst_out_n (codec_rst_n),
        .arming    (arming)
    );

    clrc_plat_fsm #(.PLAT_HOLD(PLAT_HOLD)) u_plat (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (hw_evt | deep),
        .in_hold (in_hold)
    );

    clrc_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_evt (hw_evt),
        .wr_hit (wr_hit),
        .wr_off (wr_data[OFF_BIT]),
        .off_q  (off_q)
    );

    always_comb begin
        force_low        = in_hold | low_pwr | arming;
        link_sdo         = eng_sdo  & ~force_low;
        link_sync        = eng_sync & ~force_low;
        pd_en            = off_q;
        rd_data          = '0;
        rd_data[GO_BIT]  = go_bit;
        rd_data[OFF_BIT] = off_q;
    end

    AST_RELEASE_WITH_QUIET_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(codec_rst_n) |-> $past(!link_sdo && !link_sync));  // R2
    AST_LOWPWR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_state != 3'd0) |-> (!link_sdo && !link_sync));  // R7
    AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr != CTRL_ADDR && !hw_evt && !deep) |=> $stable(rd_data));  // R10

endmodule

// File: tb/codec_link_rstctl_test.sv
`timescale 1ns/100ps
module codec_link_rstctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwrup_evt = 1'b0, hardrst_evt = 1'b0;
    logic [2:0] sleep_state = 3'd0;
    logic       wr_valid = 1'b0;
    logic [3:0] wr_addr = 4'h0;
    logic [7:0] wr_data = 8'h0;
    logic [7:0] rd_data;
    logic       eng_sdo = 1'b1, eng_sync = 1'b1;
    logic       codec_rst_n, link_sdo, link_sync, pd_en;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    codec_link_rstctl uut (
        .clk(clk), .rst_n(rst_n), .pwrup_evt(pwrup_evt), .hardrst_evt(hardrst_evt),
        .sleep_state(sleep_state), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_data(rd_data), .eng_sdo(eng_sdo), .eng_sync(eng_sync),
        .codec_rst_n(codec_rst_n), .link_sdo(link_sdo), .link_sync(link_sync), .pd_en(pd_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_valid = 1'b0;
    endtask

    task automatic done;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual 1 expected 0");
        done();
    end

    initial begin
        tick(2);
        // R1 during reset
        chk("R1 codec_rst_n", codec_rst_n, 0);
        chk("R1 link_sdo", link_sdo, 0);
        chk("R1 pd_en", pd_en, 0);
        chk("R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        tick(3);
        chk("R6 hold after reset", link_sdo, 0);
        chk("R1 codec after reset", codec_rst_n, 0);
        tick(1);
        chk("R6 follow after hold sdo", link_sdo, 1);
        chk("R6 follow after hold sync", link_sync, 1);

        // R2 release sequence
        wr(4'h6, 8'h01);
        chk("R2 go reads 1", rd_data[0], 1);
        chk("R2 codec still low in arm", codec_rst_n, 0);
        chk("R2 link low in arm", link_sdo | link_sync, 0);
        tick(1);
        chk("R2 codec released", codec_rst_n, 1);
        chk("R2 link follows", link_sdo, 1);

        // R8 shut-off bit, R10 foreign address
        wr(4'h6, 8'h03);
        chk("R8 pd_en", pd_en, 1);
        chk("R8 readback", rd_data, 3);
        wr(4'h5, 8'h00);
        chk("R10 rd unchanged", rd_data, 3);
        chk("R10 codec unchanged", codec_rst_n, 1);

        // R3 clear from LIVE
        wr(4'h6, 8'h02);
        chk("R3 codec low", codec_rst_n, 0);
        chk("R3 go reads 0", rd_data, 2);
        // R3 clear from ARM
        wr(4'h6, 8'h03);
        wr(4'h6, 8'h02);
        chk("R3 cleared in arm", rd_data[0], 0);
        chk("R3 no release from arm", codec_rst_n, 0);
        tick(1);
        chk("R3 stays low", codec_rst_n, 0);
        wr(4'h6, 8'h03);
        tick(1);
        chk("R2 released again", codec_rst_n, 1);

        // R7 sweep over shallow codes and engine inputs
        for (int s = 0; s < 3; s++) begin
            for (int e = 0; e < 4; e++) begin
                sleep_state = 3'(s);
                eng_sdo = e[0]; eng_sync = e[1];
                tick(1);
                chk("R7 link_sdo", link_sdo, (s == 0) ? e[0] : 0);
                chk("R7 link_sync", link_sync, (s == 0) ? e[1] : 0);
                chk("R7 codec unaffected", codec_rst_n, 1);
            end
        end
        sleep_state = 3'd0; eng_sdo = 1'b1; eng_sync = 1'b1;
        tick(1);

        // R5 deep codes
        for (int d = 3; d < 8; d++) begin
            sleep_state = 3'(d);
            tick(1);
            chk("R5 codec low in deep", codec_rst_n, 0);
            chk("R5 go cleared", rd_data[0], 0);
            chk("R6 link low in deep", link_sdo, 0);
            chk("R8 pd kept", pd_en, 1);
            wr(4'h6, 8'h03);
            chk("R5 go write ignored", rd_data, 2);
            chk("R5 codec still low", codec_rst_n, 0);
            sleep_state = 3'd0;
            tick(3);
            chk("R5 sticky after return", codec_rst_n, 0);
            chk("R6 hold after deep", link_sdo, 0);
            tick(1);
            chk("R6 follow after deep", link_sdo, 1);
            wr(4'h6, 8'h03);
            tick(1);
            chk("R2 release after deep", codec_rst_n, 1);
        end

        // R4 hardware events
        for (int k = 0; k < 2; k++) begin
            pwrup_evt = (k == 0); hardrst_evt = (k == 1);
            tick(1);
            pwrup_evt = 1'b0; hardrst_evt = 1'b0;
            chk("R4 codec low", codec_rst_n, 0);
            chk("R4 bits cleared", rd_data, 0);
            chk("R4 pd cleared", pd_en, 0);
            chk("R6 link low on event", link_sync, 0);
            tick(3);
            chk("R6 hold after event", link_sync, 0);
            chk("R4 no self release", codec_rst_n, 0);
            tick(1);
            chk("R6 follow after event", link_sync, 1);
            wr(4'h6, 8'h03);
            tick(1);
            chk("R2 release after event", codec_rst_n, 1);
        end

        // R9 event beats same-cycle write, from LIVE and from HELD
        hardrst_evt = 1'b1;
        wr(4'h6, 8'h03);
        hardrst_evt = 1'b0;
        chk("R9 go lost from live", rd_data, 0);
        chk("R9 codec low", codec_rst_n, 0);
        pwrup_evt = 1'b1;
        wr(4'h6, 8'h01);
        pwrup_evt = 1'b0;
        chk("R9 go lost from held", rd_data[0], 0);
        tick(1);
        chk("R9 no release", codec_rst_n, 0);

        done();
    end
endmodule